// File: doc/BRIEF.md
# Core Rail Power-Up and Power-Down Sequencer

This block steers a core-voltage regulator from a cold start to regulation and back to an unpowered state. Once the supply has passed its power-on check and the enable input is high, it waits a short settle time and then releases the gate drivers. It then ramps the soft reference upward toward a fixed boot level. When the sensed output has stayed above a qualification level long enough, it pulls the active-low clock-enable output low and moves the ramp target over to the DAC setting. After a long timer has run, it raises power-good. Mode inputs elsewhere in the regulator are to be trusted only while power-good is high.

When enable falls, power-good drops at once and the reference ramps down while the drivers stay active. Once the sensed voltage falls below a low floor, both gate drives are forced off and a discharge resistor is switched in. A separate registered flag masks under-voltage protection while the soft-ramp voltage is still below its own threshold. Analog ramp generation and conversion of the voltages are outside the block: it sees two digitised voltage codes, and all of its delays are parameters counted in clock cycles.

Top module: `core_rail_seq`

## Requirements
- R1: After reset, and for as long as the supply power-on flag is low, the outputs hold these values: drv_off=1, ramp_up=0, tgt_dac=0, clk_en_n=1, pgood=0 and dis_en=0. Raising en while the supply flag is low does not start the sequence.
- R2: The first clock edge at which both por_ok and en are sampled high starts a wait of START_DLY cycles. The drivers are released (drv_off=0) at the START_DLY-th edge after that first one.
- R3: While the rail climbs toward the boot level, ramp_up=1 and tgt_dac=0 (0 selects the boot level, 1 selects the DAC level).
- R4: clk_en_n goes low once vsense has been sampled strictly above QUAL_TH on QUAL_DLY+1 consecutive edges. A sample at or below QUAL_TH restarts the qualification.
- R5: tgt_dac becomes 1 in the same cycle that clk_en_n goes low.
- R6: pgood rises exactly PG_DLY cycles after clk_en_n falls, and pgood is never high while clk_en_n is high.
- R7: uv_mask equals (vsoft < UVM_TH) as sampled at the previous clock edge, independent of the sequence state. It resets to 1.
- R8: From the running state, en sampled low clears pgood and ramp_up on the next cycle and sets clk_en_n high, while the drivers stay active.
- R9: During ramp-down, a vsense sample strictly below OFF_TH sets drv_off=1 and dis_en=1 on the next cycle. A sample equal to OFF_TH does not.
- R10: en sampled low at any step before running (settle wait, boot ramp, qualification or power-good wait) moves the sequence straight into ramp-down.
- R11: por_ok sampled low in any state returns the sequencer to its reset outputs on the next cycle.
- R12: In the off state, en sampled high with por_ok high clears dis_en and restarts the settle wait of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | Supply power-on check passed |
| en | input | 1 | Regulator enable |
| vsense | input | VW | Digitised sensed output voltage |
| vsoft | input | VW | Digitised soft-ramp voltage |
| tgt_dac | output | 1 | Ramp target: 0 boot level, 1 DAC level |
| ramp_up | output | 1 | Ramp direction: 1 up, 0 down |
| clk_en_n | output | 1 | Active-low clock-enable |
| pgood | output | 1 | Power-good |
| uv_mask | output | 1 | Under-voltage protection mask |
| drv_off | output | 1 | Force both gate drives low |
| dis_en | output | 1 | Output discharge resistor enable |

## Verification
The bench drops vsense below the qualification level in the middle of qualification, and holds it exactly at that level. A design that kept its count across a dip, or that compared with >=, would pull clock-enable low too early. Both threshold comparisons are probed at their exact codes, and the power-good timer is sampled one cycle before and one cycle after its expiry, which catches off-by-one errors in the counter limits. The bench also drops enable during qualification, restarts from the off state, and removes the supply flag while running. A sequencer that ignored these events would keep power-good high, leave the discharge path on, or keep driving after power-on was lost.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE       = 4'd0,
    ST_DELAY      = 4'd1,
    ST_BOOT_RAMP  = 4'd2,
    ST_CLK_QUAL   = 4'd3,
    ST_DAC_RAMP   = 4'd4,
    ST_PGOOD_WAIT = 4'd5,
    ST_RUN        = 4'd6,
    ST_RAMP_DOWN  = 4'd7,
    ST_OFF        = 4'd8
  } seq_state_e;

  typedef struct packed {
    logic drv_off;
    logic ramp_up;
    logic tgt_dac;
    logic clk_en_n;
    logic pgood;
    logic dis_en;
  } seq_out_t;

  // Output pattern held in each sequencer state.
  function automatic seq_out_t state_outputs(seq_state_e s);
    seq_out_t o;
    o = '{drv_off: 1'b1, ramp_up: 1'b0, tgt_dac: 1'b0,
          clk_en_n: 1'b1, pgood: 1'b0, dis_en: 1'b0};
    case (s)
      ST_BOOT_RAMP, ST_CLK_QUAL: begin
        o.drv_off = 1'b0;
        o.ramp_up = 1'b1;
      end
      ST_DAC_RAMP, ST_PGOOD_WAIT: begin
        o.drv_off  = 1'b0;
        o.ramp_up  = 1'b1;
        o.tgt_dac  = 1'b1;
        o.clk_en_n = 1'b0;
      end
      ST_RUN: begin
        o.drv_off  = 1'b0;
        o.ramp_up  = 1'b1;
        o.tgt_dac  = 1'b1;
        o.clk_en_n = 1'b0;
        o.pgood    = 1'b1;
      end
      ST_RAMP_DOWN: begin
        o.drv_off = 1'b0;
      end
      ST_OFF: begin
        o.dis_en = 1'b1;
      end
      default: ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/crs_thresh.sv
module crs_thresh #(
  parameter int VW      = 10,
  parameter int QUAL_TH = 500,
  parameter int OFF_TH  = 100,
  parameter int UVM_TH  = 500
) (
  input  logic [VW-1:0] vsense,
  input  logic [VW-1:0] vsoft,
  output logic          above_qual,
  output logic          below_off,
  output logic          soft_low
);

  localparam logic [VW-1:0] QUAL_CODE = VW'(QUAL_TH);
  localparam logic [VW-1:0] OFF_CODE  = VW'(OFF_TH);
  localparam logic [VW-1:0] UVM_CODE  = VW'(UVM_TH);

  always_comb begin
    above_qual = (vsense > QUAL_CODE);
    below_off  = (vsense < OFF_CODE);
    soft_low   = (vsoft  < UVM_CODE);
  end

endmodule

// File: rtl/crs_timer.sv
module crs_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          hit
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit = (cnt_q == limit);

endmodule

// File: rtl/crs_fsm.sv
module crs_fsm
  import crs_pkg::*;
#(
  parameter int CW        = 8,
  parameter int START_DLY = 4,
  parameter int QUAL_DLY  = 4,
  parameter int PG_DLY    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          por_ok,
  input  logic          en,
  input  logic          above_qual,
  input  logic          below_off,
  input  logic          tmr_hit,
  output seq_state_e    state_q,
  output seq_state_e    state_d,
  output logic          tmr_clr,
  output logic          tmr_inc,
  output logic [CW-1:0] tmr_limit
);

  localparam logic [CW-1:0] LIM_START = CW'(START_DLY - 1);
  localparam logic [CW-1:0] LIM_QUAL  = CW'(QUAL_DLY - 1);
  localparam logic [CW-1:0] LIM_PG    = CW'(PG_DLY - 2);

  always_comb begin
    state_d = state_q;
    if (!por_ok) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:       if (en) state_d = ST_DELAY;
        ST_DELAY:      if (!en) state_d = ST_RAMP_DOWN;
                       else if (tmr_hit) state_d = ST_BOOT_RAMP;
        ST_BOOT_RAMP:  if (!en) state_d = ST_RAMP_DOWN;
                       else if (above_qual) state_d = ST_CLK_QUAL;
        ST_CLK_QUAL:   if (!en) state_d = ST_RAMP_DOWN;
                       else if (!above_qual) state_d = ST_BOOT_RAMP;
                       else if (tmr_hit) state_d = ST_DAC_RAMP;
        ST_DAC_RAMP:   if (!en) state_d = ST_RAMP_DOWN;
                       else state_d = ST_PGOOD_WAIT;
        ST_PGOOD_WAIT: if (!en) state_d = ST_RAMP_DOWN;
                       else if (tmr_hit) state_d = ST_RUN;
        ST_RUN:        if (!en) state_d = ST_RAMP_DOWN;
        ST_RAMP_DOWN:  if (below_off) state_d = ST_OFF;
        ST_OFF:        if (en) state_d = ST_DELAY;
        default:       state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tmr_limit = '1;
    tmr_inc   = 1'b0;
    case (state_q)
      ST_DELAY:      begin tmr_limit = LIM_START; tmr_inc = 1'b1; end
      ST_CLK_QUAL:   begin tmr_limit = LIM_QUAL;  tmr_inc = 1'b1; end
      ST_PGOOD_WAIT: begin tmr_limit = LIM_PG;    tmr_inc = 1'b1; end
      default: ;
    endcase
    tmr_clr = (state_d != state_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/core_rail_seq.sv
module core_rail_seq
  import crs_pkg::*;
#(
  parameter int VW        = 10,
  parameter int QUAL_TH   = 500,
  parameter int OFF_TH    = 100,
  parameter int UVM_TH    = 500,
  parameter int START_DLY = 2500,
  parameter int QUAL_DLY  = 9125,
  parameter int PG_DLY    = 587500
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          por_ok,
  input  logic          en,
  input  logic [VW-1:0] vsense,
  input  logic [VW-1:0] vsoft,
  output logic          tgt_dac,
  output logic          ramp_up,
  output logic          clk_en_n,
  output logic          pgood,
  output logic          uv_mask,
  output logic          drv_off,
  output logic          dis_en
);

  localparam int MAX_A  = (START_DLY > QUAL_DLY) ? START_DLY : QUAL_DLY;
  localparam int MAX_D  = (MAX_A > PG_DLY) ? MAX_A : PG_DLY;
  localparam int CW     = $clog2(MAX_D + 1) + 1;

  logic          above_qual;
  logic          below_off;
  logic          soft_low;
  logic          tmr_clr;
  logic          tmr_inc;
  logic          tmr_hit;
  logic [CW-1:0] tmr_limit;
  seq_state_e    state_q;
  seq_state_e    state_d;
  seq_out_t      out_q;
  logic          uv_q;

  crs_thresh #(
    .VW(VW), .QUAL_TH(QUAL_TH), .OFF_TH(OFF_TH), .UVM_TH(UVM_TH)
  ) u_thresh (
    .vsense(vsense), .vsoft(vsoft),
    .above_qual(above_qual), .below_off(below_off), .soft_low(soft_low)
  );

  crs_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .inc(tmr_inc),
    .limit(tmr_limit), .hit(tmr_hit)
  );

  crs_fsm #(
    .CW(CW), .START_DLY(START_DLY), .QUAL_DLY(QUAL_DLY), .PG_DLY(PG_DLY)
  ) u_fsm (
    .clk(clk), .rst(rst), .por_ok(por_ok), .en(en),
    .above_qual(above_qual), .below_off(below_off), .tmr_hit(tmr_hit),
    .state_q(state_q), .state_d(state_d),
    .tmr_clr(tmr_clr), .tmr_inc(tmr_inc), .tmr_limit(tmr_limit)
  );

  // Outputs registered from the next-state decode so they line up with state_q.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= state_outputs(ST_IDLE);
      uv_q  <= 1'b1;
    end else begin
      out_q <= state_outputs(state_d);
      uv_q  <= soft_low;
    end
  end

  assign drv_off  = out_q.drv_off;
  assign ramp_up  = out_q.ramp_up;
  assign tgt_dac  = out_q.tgt_dac;
  assign clk_en_n = out_q.clk_en_n;
  assign pgood    = out_q.pgood;
  assign dis_en   = out_q.dis_en;
  assign uv_mask  = uv_q;

endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int VW     = 10,
  parameter int UVM_TH = 500
) (
  input logic          clk,
  input logic          rst,
  input logic          por_ok,
  input logic          en,
  input logic [VW-1:0] vsoft,
  input logic          tgt_dac,
  input logic          ramp_up,
  input logic          clk_en_n,
  input logic          pgood,
  input logic          uv_mask,
  input logic          drv_off,
  input logic          dis_en
);

  assert_pgood_needs_clk_R6: assert property (@(posedge clk) disable iff (rst)
    pgood |-> !clk_en_n);

  assert_retarget_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en_n) |-> tgt_dac);

  assert_boot_target_R3: assert property (@(posedge clk) disable iff (rst)
    (ramp_up && clk_en_n) |-> !tgt_dac);

  assert_pgood_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (por_ok && !en) |=> !pgood);

  assert_por_loss_R11: assert property (@(posedge clk) disable iff (rst)
    !por_ok |=> (drv_off && !pgood && clk_en_n && !ramp_up && !dis_en));

  assert_discharge_off_R9: assert property (@(posedge clk) disable iff (rst)
    dis_en |-> drv_off);

  assert_uv_mask_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (uv_mask == ($past(vsoft) < VW'(UVM_TH))));

endmodule

bind core_rail_seq crs_checker #(.VW(VW), .UVM_TH(UVM_TH)) u_crs_checker (
  .clk(clk), .rst(rst), .por_ok(por_ok), .en(en), .vsoft(vsoft),
  .tgt_dac(tgt_dac), .ramp_up(ramp_up), .clk_en_n(clk_en_n), .pgood(pgood),
  .uv_mask(uv_mask), .drv_off(drv_off), .dis_en(dis_en)
);

// File: tb/core_rail_seq_bench.sv
module core_rail_seq_bench;

  localparam int VW  = 10;
  localparam int QTH = 500;
  localparam int OTH = 100;
  localparam int UTH = 500;
  localparam int SD  = 6;
  localparam int QD  = 10;
  localparam int PD  = 30;

  localparam int M_IDLE = 0, M_WAIT = 1, M_BOOT = 2, M_QUAL = 3, M_DACR = 4,
                 M_PGW = 5, M_RUN = 6, M_DOWN = 7, M_OFF = 8;

  logic clk = 1'b0;
  logic rst, por_ok, en;
  logic [VW-1:0] vsense, vsoft;
  logic tgt_dac, ramp_up, clk_en_n, pgood, uv_mask, drv_off, dis_en;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  core_rail_seq #(
    .VW(VW), .QUAL_TH(QTH), .OFF_TH(OTH), .UVM_TH(UTH),
    .START_DLY(SD), .QUAL_DLY(QD), .PG_DLY(PD)
  ) u_core_rail_seq (
    .clk(clk), .rst(rst), .por_ok(por_ok), .en(en),
    .vsense(vsense), .vsoft(vsoft),
    .tgt_dac(tgt_dac), .ramp_up(ramp_up), .clk_en_n(clk_en_n),
    .pgood(pgood), .uv_mask(uv_mask), .drv_off(drv_off), .dis_en(dis_en)
  );

  // Behavioural reference: phase plus cycles spent in it.
  int  ph = M_IDLE;
  int  age = 0;
  bit  exp_uv = 1;

  always @(posedge clk) begin
    int nx;
    if (rst) begin
      ph = M_IDLE; age = 0; exp_uv = 1;
    end else begin
      exp_uv = (vsoft < UTH);
      nx = ph;
      if (!por_ok) nx = M_IDLE;
      else if (ph == M_IDLE) begin if (en) nx = M_WAIT; end
      else if (ph == M_DOWN) begin if (vsense < OTH) nx = M_OFF; end
      else if (ph == M_OFF)  begin if (en) nx = M_WAIT; end
      else if (!en) nx = M_DOWN;
      else if (ph == M_WAIT && age + 1 == SD) nx = M_BOOT;
      else if (ph == M_BOOT && vsense > QTH) nx = M_QUAL;
      else if (ph == M_QUAL && !(vsense > QTH)) nx = M_BOOT;
      else if (ph == M_QUAL && age + 1 == QD) nx = M_DACR;
      else if (ph == M_DACR) nx = M_PGW;
      else if (ph == M_PGW && age + 2 == PD) nx = M_RUN;
      age = (nx == ph) ? age + 1 : 0;
      ph = nx;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    cycles++;
    if (!rst && !done) begin
      check("R9", "drv_off", drv_off, (ph == M_IDLE || ph == M_WAIT || ph == M_OFF));
      check("R3", "ramp_up", ramp_up, (ph >= M_BOOT && ph <= M_RUN));
      check("R5", "tgt_dac", tgt_dac, (ph >= M_DACR && ph <= M_RUN));
      check("R4", "clk_en_n", clk_en_n, !(ph >= M_DACR && ph <= M_RUN));
      check("R6", "pgood", pgood, (ph == M_RUN));
      check("R9", "dis_en", dis_en, (ph == M_OFF));
      check("R7", "uv_mask", uv_mask, exp_uv);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    step(20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1; por_ok = 0; en = 0; vsense = '0; vsoft = '0;
    step(3);
    rst = 0;
    step(2);
    // R1: reset outputs
    check("R1", "drv_off", drv_off, 1);
    check("R1", "clk_en_n", clk_en_n, 1);
    check("R1", "pgood", pgood, 0);
    check("R1", "uv_mask", uv_mask, 1);
    // R1: enable without supply flag does nothing
    en = 1;
    step(5);
    check("R1", "ramp_up no por", ramp_up, 0);
    check("R1", "drv_off no por", drv_off, 1);
    // R2: settle wait
    por_ok = 1;
    step(SD);
    check("R2", "drv_off before wait end", drv_off, 1);
    step(1);
    check("R2", "drv_off after wait", drv_off, 0);
    check("R3", "ramp_up boot", ramp_up, 1);
    check("R3", "tgt_dac boot", tgt_dac, 0);
    // R4: at threshold does not qualify, dip restarts
    vsense = 10'(QTH);
    step(QD + 4);
    check("R4", "clk_en_n at threshold", clk_en_n, 1);
    vsense = 600;
    step(4);
    vsense = 300;
    step(2);
    vsense = 600;
    step(QD);
    check("R4", "clk_en_n one short", clk_en_n, 1);
    step(1);
    check("R4", "clk_en_n qualified", clk_en_n, 0);
    check("R5", "tgt_dac with clk_en", tgt_dac, 1);
    // R6: power-good timer
    step(PD - 1);
    check("R6", "pgood before timer", pgood, 0);
    step(1);
    check("R6", "pgood after timer", pgood, 1);
    // R7: mask follows soft voltage
    vsoft = 600;
    step(1);
    check("R7", "uv_mask high soft", uv_mask, 0);
    vsoft = 10'(UTH);
    step(1);
    check("R7", "uv_mask at threshold", uv_mask, 0);
    vsoft = 100;
    step(1);
    check("R7", "uv_mask low soft", uv_mask, 1);
    // R8: shutdown from run
    en = 0;
    step(1);
    check("R8", "pgood drop", pgood, 0);
    check("R8", "ramp_up down", ramp_up, 0);
    check("R8", "drv still on", drv_off, 0);
    check("R8", "clk_en_n released", clk_en_n, 1);
    // R9: floor comparison
    vsense = 10'(OTH);
    step(2);
    check("R9", "drv_off at floor", drv_off, 0);
    vsense = 10'(OTH - 1);
    step(1);
    check("R9", "drv_off below floor", drv_off, 1);
    check("R9", "dis_en below floor", dis_en, 1);
    // R12: restart from off
    vsense = 0;
    en = 1;
    step(1);
    check("R12", "dis_en cleared", dis_en, 0);
    check("R12", "drv_off in wait", drv_off, 1);
    step(SD);
    check("R12", "drv released", drv_off, 0);
    // R10: abort during qualification
    vsense = 600;
    step(3);
    en = 0;
    step(1);
    check("R10", "ramp_up abort", ramp_up, 0);
    check("R10", "drv on abort", drv_off, 0);
    vsense = 50;
    step(2);
    check("R10", "off after abort", dis_en, 1);
    // R11: supply loss while running
    vsense = 0;
    en = 1;
    step(SD + 1);
    vsense = 600;
    step(QD + 1 + PD);
    check("R11", "pgood before loss", pgood, 1);
    por_ok = 0;
    step(1);
    check("R11", "pgood after loss", pgood, 0);
    check("R11", "drv_off after loss", drv_off, 1);
    check("R11", "clk_en_n after loss", clk_en_n, 1);
    por_ok = 1; en = 0;
    step(3);
    check("R11", "idle stays off", dis_en, 0);
    finish_run();
  end

endmodule